// File: doc/BRIEF.md
# CPU Interrupt Priority Controller

This block sits between a set of interrupt lines and one processor core. Software configures each line through a small register port: an enable bit, a trigger kind (level or edge), a 4-bit priority, and one shared priority threshold. A write-one-to-clear register drops latched edge requests. Each cycle the block looks at every line that is enabled, pending, has a nonzero priority and a priority at or above the threshold. It picks the highest-priority one and presents a single request to the core, together with that line's number.

The threshold is what makes nested service possible. A trap handler raises the threshold to its own priority plus one, which masks interrupts of equal and lower priority. It restores the old value on exit. Line numbering starts at 1, and lines 1 to `NUM_LINES` exist (default 19, at most 30). Line 0, the lines above `NUM_LINES`, and slot 31 in particular are never able to raise a request. Slot 31 is the place an upstream router sends sources it wants disconnected.

Reads are combinational on `bus_addr`. A write takes effect when `bus_valid` and `bus_write` are both high at a rising clock edge. Reset is synchronous and active low.

Top module: `irqpri_ctrl`

## Requirements
- R1: After reset the enable, trigger-kind, priority and threshold registers read 0, `irq_req` is 0 and `irq_id` is 0.
- R2: The register offsets are as follows. Bit n of the enable mask at 0x00 and bit n of the trigger-kind mask at 0x04 belong to line n; only bits 1..NUM_LINES are stored, and all other bits read 0. The priority of line n sits in bits 3:0 of the word at 0x10+4n. The threshold sits in bits 7:0 at 0x90. All unused bits read 0.
- R3: Writing 1 to bit n at 0x08 clears the latched edge request of line n. Zero bits leave the corresponding lines untouched. The value written is not stored, and 0x08 reads 0.
- R4: With trigger-kind bit 0 (level), a line is pending exactly while its input, sampled by one flop, is high. A clear write has no effect on a level line.
- R5: With trigger-kind bit 1 (edge), a rising input edge sets a pending flag, which holds until cleared. If an edge and a clear for the same line arrive in the same cycle, the edge wins.
- R6: A line is eligible only when it is enabled, pending, and has a nonzero priority.
- R7: Among eligible lines, the highest priority wins. On a priority tie, the lowest line number wins.
- R8: `irq_req` and `irq_id` are registered. A line input that changes before edge k shows up at the outputs after edge k+1. A register write at edge k shows up after edge k+1. While there is no request, `irq_id` is 0.
- R9: Line 0, lines above NUM_LINES and slot 31 never request. Their priority words read 0.
- R10: A line needs priority >= threshold (8-bit compare) to be eligible. A threshold of p+1 masks priority p and below, and a threshold of 16 or more masks every line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| line_src | input | 32 | Interrupt line inputs; bit n is line n |
| irq_req | output | 1 | Interrupt request to the core |
| irq_id | output | 5 | Number of the winning line, 0 when idle |

## Verification
The main selection function is driven from a table of line-input patterns over a fixed priority layout. The patterns are chosen to separate distinct cases:
- a single line against none;
- a zero-priority line that must stay silent;
- a strict priority order against a priority tie, which exposes the lowest-number rule;
- the highest priority value against a middle one;
- a nonexistent line 0.

Directed sequences then cover the threshold at, just above and far above a line's priority, and an edge line held after its input falls. They also check partial and full clears, a clear aimed at a level line, and an edge arriving in the same cycle as its clear. Each directed sequence samples the outputs in the exact cycle the two-register latency predicts.

// File: rtl/irqpri_pkg.sv
// Shared widths and register offsets of the interrupt priority controller.
package irqpri_pkg;
    localparam int DATA_W = 32;   // register word width
    localparam int ADDR_W = 8;    // byte offset width
    localparam int PRIO_W = 4;    // per-line priority width
    localparam int THR_W  = 8;    // stored threshold width
    localparam int SLOTS  = 32;   // line slots addressed by the bitmasks
    localparam int ID_W   = $clog2(SLOTS);

    localparam logic [ADDR_W-1:0] OFF_EN   = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_KIND = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_CLR  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_PRIO = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_THR  = 8'h90;
endpackage

// File: rtl/irqpri_regs.sv
// Register file: enable mask, trigger-kind mask, per-line priority and
// threshold, plus the write-one-to-clear strobe.
// Assumes 1 <= NUM_LINES <= 30; reads are combinational on bus_addr.
module irqpri_regs
    import irqpri_pkg::*;
#(
    parameter int NUM_LINES = 19
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bus_valid,
    input  logic                             bus_write,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [DATA_W-1:0]                bus_wdata,
    output logic [DATA_W-1:0]                bus_rdata,
    output logic [NUM_LINES:1]               en_v,
    output logic [NUM_LINES:1]               edge_v,
    output logic [NUM_LINES:1]               clr_v,
    output logic [NUM_LINES:1][PRIO_W-1:0]   prio_v,
    output logic [THR_W-1:0]                 thr
);
    logic wr;
    logic unused_wdata;

    assign wr           = bus_valid && bus_write;
    assign unused_wdata = ^bus_wdata[DATA_W-1:NUM_LINES+1];

    // Enable and trigger-kind masks, one bit per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_v   <= '0;
            edge_v <= '0;
        end else if (wr && bus_addr == OFF_EN) begin
            en_v   <= bus_wdata[NUM_LINES:1];
        end else if (wr && bus_addr == OFF_KIND) begin
            edge_v <= bus_wdata[NUM_LINES:1];
        end
    end

    // Threshold register, low byte only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            thr <= '0;
        else if (wr && bus_addr == OFF_THR)
            thr <= bus_wdata[THR_W-1:0];
    end

    // Clear strobe lasts only the write cycle and is never stored.
    assign clr_v = (wr && bus_addr == OFF_CLR) ? bus_wdata[NUM_LINES:1] : '0;

    // One priority register per implemented line.
    for (genvar g = 1; g <= NUM_LINES; g++) begin : g_prio
        localparam logic [ADDR_W-1:0] MY_OFF = ADDR_W'(int'(OFF_PRIO) + 4 * g);
        logic [PRIO_W-1:0] pr;
        always_ff @(posedge clk) begin
            if (!rst_n)
                pr <= '0;
            else if (wr && bus_addr == MY_OFF)
                pr <= bus_wdata[PRIO_W-1:0];
        end
        assign prio_v[g] = pr;
    end

    // Read multiplexer; unmapped offsets and unused bits return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFF_EN)
            bus_rdata[NUM_LINES:1] = en_v;
        else if (bus_addr == OFF_KIND)
            bus_rdata[NUM_LINES:1] = edge_v;
        else if (bus_addr == OFF_THR)
            bus_rdata[THR_W-1:0] = thr;
        else
            for (int i = 1; i <= NUM_LINES; i++)
                if (bus_addr == ADDR_W'(int'(OFF_PRIO) + 4 * i))
                    bus_rdata[PRIO_W-1:0] = prio_v[i];
    end

    p_clear_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_CLR) |-> (bus_rdata == '0));

    p_thr_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_THR) |-> (bus_rdata[DATA_W-1:THR_W] == '0));
endmodule

// File: rtl/irqpri_pend.sv
// Pending state per line: level lines follow the sampled input, edge lines
// latch a rising edge until a clear. Assumes line inputs are synchronous.
module irqpri_pend
    import irqpri_pkg::*;
#(
    parameter int NUM_LINES = 19
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES:1]   src,
    input  logic [NUM_LINES:1]   edge_v,
    input  logic [NUM_LINES:1]   clr_v,
    output logic [NUM_LINES:1]   pend_v
);
    logic [NUM_LINES:1] src_q;
    logic [NUM_LINES:1] latch_v;
    logic [NUM_LINES:1] held_v;

    // Input sample, also the reference for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src;
    end

    for (genvar g = 1; g <= NUM_LINES; g++) begin : g_line
        logic lat;
        // Edge latch: set on rise (wins over clear), dropped in level mode.
        always_ff @(posedge clk) begin
            if (!rst_n || !edge_v[g])
                lat <= 1'b0;
            else if (src[g] && !src_q[g])
                lat <= 1'b1;
            else if (clr_v[g])
                lat <= 1'b0;
        end
        assign latch_v[g] = lat;
        assign pend_v[g]  = edge_v[g] ? lat : src_q[g];
    end

    assign held_v = latch_v & edge_v & ~clr_v;

    p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (held_v != '0) |=> ((($past(held_v) & ~latch_v) == '0) || ($past(edge_v) != edge_v)));
endmodule

// File: rtl/irqpri_arb.sv
// Priority selection: filters eligible lines against the threshold and
// registers the highest-priority, lowest-numbered winner.
module irqpri_arb
    import irqpri_pkg::*;
#(
    parameter int NUM_LINES = 19
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_LINES:1]               en_v,
    input  logic [NUM_LINES:1]               pend_v,
    input  logic [NUM_LINES:1][PRIO_W-1:0]   prio_v,
    input  logic [THR_W-1:0]                 thr,
    output logic                             irq_req,
    output logic [ID_W-1:0]                  irq_id
);
    logic [NUM_LINES:1] cand;
    logic [PRIO_W-1:0]  best_p;
    logic [ID_W-1:0]    best_id;
    logic               found;

    for (genvar g = 1; g <= NUM_LINES; g++) begin : g_cand
        assign cand[g] = en_v[g] && pend_v[g] && (prio_v[g] != '0) &&
                         ({{(THR_W-PRIO_W){1'b0}}, prio_v[g]} >= thr);
    end

    // Scan upward; strict compare keeps the lowest number on a tie.
    always_comb begin
        best_p  = '0;
        best_id = '0;
        found   = 1'b0;
        for (int i = 1; i <= NUM_LINES; i++) begin
            if (cand[i] && prio_v[i] > best_p) begin
                best_p  = prio_v[i];
                best_id = ID_W'(i);
                found   = 1'b1;
            end
        end
    end

    // Output register toward the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
            irq_id  <= '0;
        end else begin
            irq_req <= found;
            irq_id  <= best_id;
        end
    end
endmodule

// File: rtl/irqpri_ctrl.sv
// Top of the interrupt priority controller: register port, pending capture
// and arbitration. Assumes 1 <= NUM_LINES <= 30 so slot 31 stays unconnected.
module irqpri_ctrl
    import irqpri_pkg::*;
#(
    parameter int NUM_LINES = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [SLOTS-1:0]  line_src,
    output logic              irq_req,
    output logic [ID_W-1:0]   irq_id
);
    logic [NUM_LINES:1]             en_v, edge_v, clr_v, pend_v;
    logic [NUM_LINES:1][PRIO_W-1:0] prio_v;
    logic [THR_W-1:0]               thr;
    logic                           unused_src;

    assign unused_src = ^{line_src[SLOTS-1:NUM_LINES+1], line_src[0]};

    irqpri_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .en_v(en_v), .edge_v(edge_v), .clr_v(clr_v), .prio_v(prio_v), .thr(thr)
    );

    irqpri_pend #(.NUM_LINES(NUM_LINES)) u_pend (
        .clk(clk), .rst_n(rst_n), .src(line_src[NUM_LINES:1]),
        .edge_v(edge_v), .clr_v(clr_v), .pend_v(pend_v)
    );

    irqpri_arb #(.NUM_LINES(NUM_LINES)) u_arb (
        .clk(clk), .rst_n(rst_n), .en_v(en_v), .pend_v(pend_v),
        .prio_v(prio_v), .thr(thr), .irq_req(irq_req), .irq_id(irq_id)
    );

    // Assertion support: previous-cycle view of live lines and priorities.
    logic [SLOTS-1:0]             live_q;
    logic [SLOTS-1:0][PRIO_W-1:0] prio_q;

    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= '0;
        else        live_q <= {{(SLOTS-NUM_LINES-1){1'b0}}, en_v & pend_v, 1'b0};
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_shadow
        if (g >= 1 && g <= NUM_LINES) begin : g_on
            always_ff @(posedge clk) begin
                if (!rst_n) prio_q[g] <= '0;
                else        prio_q[g] <= prio_v[g];
            end
        end else begin : g_off
            assign prio_q[g] = '0;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_req && irq_id == '0));

    p_id_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_id != '0 && int'(irq_id) <= NUM_LINES));

    p_idle_id_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_id == '0));

    p_winner_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> live_q[irq_id]);

    p_winner_above_thr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (prio_q[irq_id] != '0 &&
                     {{(THR_W-PRIO_W){1'b0}}, prio_q[irq_id]} >= $past(thr)));
endmodule

// File: tb/test_irqpri_ctrl.sv
`timescale 1ns/1ps
module test_irqpri_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] line_src = '0;
    logic        irq_req;
    logic [4:0]  irq_id;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    irqpri_ctrl i_irqpri_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .line_src(line_src), .irq_req(irq_req), .irq_id(irq_id)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_out(input string rq, input logic req, input logic [4:0] id);
        check(rq, {26'd0, irq_req, irq_id}, {26'd0, req, id});
    endtask

    function automatic logic [3:0] tprio(input int n);
        case (n)
            3: return 4'd5;   5: return 4'd9;   7: return 4'd9;
            10: return 4'd15; 12: return 4'd0;  19: return 4'd9;
            default: return 4'd1;
        endcase
    endfunction

    // {line inputs, expected request, expected id}; all lines level, threshold 0
    localparam logic [37:0] VEC [10] = '{
        {32'h0000_0000, 1'b0, 5'd0},    // R6 nothing pending
        {32'h0000_0002, 1'b1, 5'd1},    // R6 single line
        {32'h0000_1000, 1'b0, 5'd0},    // R6 priority 0 stays silent
        {32'h0000_000A, 1'b1, 5'd3},    // R7 5 beats 1
        {32'h0000_00A8, 1'b1, 5'd5},    // R7 tie at 9 -> lowest number
        {32'h0008_0080, 1'b1, 5'd7},    // R7 tie 7 vs 19
        {32'h0000_0420, 1'b1, 5'd10},   // R7 15 beats 9
        {32'h0000_0014, 1'b1, 5'd2},    // R7 tie at 1
        {32'h0008_1000, 1'b1, 5'd19},   // R6 zero-priority loser
        {32'h0000_0001, 1'b0, 5'd0}     // R9 line 0 absent
    };

    initial begin
        logic [31:0] d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk_out("R1", 1'b0, 5'd0);
        rd(8'h00, d); check("R1", d, 32'h0);
        rd(8'h04, d); check("R1", d, 32'h0);
        rd(8'h90, d); check("R1", d, 32'h0);
        rd(8'h14, d); check("R1", d, 32'h0);
        rd(8'h5C, d); check("R1", d, 32'h0);

        // R2 map and stored bits
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); check("R2", d, 32'h000F_FFFE);
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, d); check("R2", d, 32'h000F_FFFE);
        wr(8'h04, 32'h0);
        wr(8'h1C, 32'hFFFF_FFF5); rd(8'h1C, d); check("R2", d, 32'h5);
        wr(8'h90, 32'hABCD_EF1F); rd(8'h90, d); check("R2", d, 32'h1F);
        wr(8'h90, 32'h0);
        wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, d); check("R3", d, 32'h0);
        wr(8'h8C, 32'h0000_000F); rd(8'h8C, d); check("R9", d, 32'h0);

        // table of priorities, then the vector walk
        for (int n = 1; n <= 19; n++) wr(8'(8'h10 + 4 * n), {28'd0, tprio(n)});
        for (int v = 0; v < 10; v++) begin
            @(negedge clk);
            line_src = VEC[v][37:6];
            idle(3);
            chk_out("R7", VEC[v][5], VEC[v][4:0]);
        end
        line_src = '0; idle(3);

        // R8 latency: input before edge k, output after edge k+1
        @(negedge clk); line_src = 32'h2;
        @(negedge clk); chk_out("R8", 1'b0, 5'd0);
        @(negedge clk); chk_out("R8", 1'b1, 5'd1);
        line_src = '0; idle(3);

        // R10 threshold
        line_src = 32'h28; idle(3); chk_out("R10", 1'b1, 5'd5);
        wr(8'h90, 32'd9);   idle(1); chk_out("R10", 1'b1, 5'd5);
        wr(8'h90, 32'd10);  idle(1); chk_out("R10", 1'b0, 5'd0);
        line_src = 32'h428; idle(3); chk_out("R10", 1'b1, 5'd10);
        wr(8'h90, 32'd16);  idle(1); chk_out("R10", 1'b0, 5'd0);
        wr(8'h90, 32'd0);
        line_src = '0; idle(3);

        // R9 slot 31 and line 0 never request
        line_src = 32'h8000_0001; idle(3); chk_out("R9", 1'b0, 5'd0);
        line_src = '0; idle(2);

        // R5 edge capture and hold on line 4
        wr(8'h04, 32'h10);
        wr(8'h20, 32'd7);
        @(negedge clk); line_src = 32'h10;
        @(negedge clk); line_src = 32'h0;
        idle(1); chk_out("R5", 1'b1, 5'd4);
        idle(5); chk_out("R5", 1'b1, 5'd4);
        wr(8'h08, 32'hFFFF_FFEF); idle(2); chk_out("R3", 1'b1, 5'd4);
        wr(8'h08, 32'h10);
        chk_out("R8", 1'b1, 5'd4);
        @(negedge clk); chk_out("R3", 1'b0, 5'd0);

        // R5 edge and clear in the same cycle: edge wins
        @(negedge clk);
        line_src = 32'h10;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h10;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; line_src = 32'h0;
        idle(3); chk_out("R5", 1'b1, 5'd4);
        wr(8'h08, 32'h10); idle(2); chk_out("R5", 1'b0, 5'd0);

        // R4 level line ignores clear and follows input
        line_src = 32'h2; idle(3); chk_out("R4", 1'b1, 5'd1);
        wr(8'h08, 32'h2); idle(2); chk_out("R4", 1'b1, 5'd1);
        line_src = 32'h0; idle(2); chk_out("R4", 1'b0, 5'd0);

        // R6 disabled line does not request
        line_src = 32'h2; idle(3);
        wr(8'h00, 32'hFFFF_FFFD); idle(1); chk_out("R6", 1'b0, 5'd0);
        wr(8'h00, 32'hFFFF_FFFF); idle(1); chk_out("R6", 1'b1, 5'd1);
        line_src = '0; idle(3);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule